// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Engine

This block runs one read or write cycle at a time as master of an asynchronous, handshaked bus. An internal client presents an address, write data, a direction flag, a transfer size (byte or 16-bit word) and a bus-width setting. The engine steps through a fixed strobe sequence. It first drives the address and the direction line. It then asserts the address strobe, then the data strobe or strobes. It holds everything steady until the slave answers with an acknowledge. After that it releases the strobes, returns the read data and pulses a completion flag.

The two strobe pins change meaning with the bus-width setting. On a 16-bit bus they are per-byte lane strobes: the upper strobe covers bits 15:8 and the lower strobe covers bits 7:0. On an 8-bit bus the upper pin carries address bit 0 and the lower pin is the only data strobe, so all data moves on bits 7:0. The acknowledge is asynchronous. It passes through a synchronizer, and a new cycle is held off until the acknowledge of the previous cycle has gone away.

Top module: `abm_cycle_engine`

## Requirements
- R1: After reset the address strobe, both strobe pins and the direction line are high, the completion flag and the write-data enable are low, and the request ready is high while the acknowledge is negated.
- R2: The cycle accepted at clock edge E0 drives the address bits 23:1 and the direction at E0. The address strobe goes low at E0+1, and the data strobe(s) go low at E0+2. No data strobe is ever low while the address strobe is high.
- R3: While the acknowledge input stays high, the address and data strobes stay asserted, with no limit on wait cycles. When the acknowledge falls, the strobes are negated on the third rising edge after the fall, which covers two synchronizer cycles.
- R4: The direction line is high for a read and low for a write, and it does not change while the address strobe is asserted.
- R5: On a 16-bit bus (cfg_bus8=0) a word transfer asserts both strobes. A byte transfer at an even address (addr[0]=0) asserts only the upper strobe. A byte transfer at an odd address asserts only the lower strobe.
- R6: On a 16-bit bus a word write drives req_wdata on all 16 bits. A byte write drives req_wdata[7:0] on the selected lane and zero on the other lane. A word read returns bus_din. A byte read returns the selected lane in rsp_rdata[7:0], with zero above it.
- R7: On an 8-bit bus (cfg_bus8=1) the upper-strobe pin outputs addr[0] from E0 until the cycle ends, and the lower-strobe pin is the data strobe. Write data is {8'h00, req_wdata[7:0]}, read data is {8'h00, bus_din[7:0]}, and req_word is ignored.
- R8: Read data is captured on the edge where the strobes are negated. Later changes on bus_din do not alter rsp_rdata.
- R9: rsp_done is high for exactly one cycle, in the cycle that follows the strobe negation.
- R10: req_ready is low whenever the synchronized acknowledge is still asserted, so a lingering acknowledge can neither start nor end the next cycle early.
- R11: For a write, bus_dout_en rises at E0+1, before any data strobe, and falls one cycle after the strobes are negated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client requests a cycle |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_wdata | input | 16 | Write data (byte transfers use bits 7:0) |
| cfg_bus8 | input | 1 | 1 = 8-bit data bus, 0 = 16-bit |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, right-justified for bytes |
| bus_addr | output | 23 | Address bits 23:1 |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_rw | output | 1 | Direction: high read, low write |
| bus_uds_n | output | 1 | Upper strobe (16-bit) or address bit 0 (8-bit) |
| bus_lds_n | output | 1 | Lower strobe (16-bit) or data strobe (8-bit) |
| bus_dout | output | 16 | Write data to the bus |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data from the bus |
| bus_ack_n | input | 1 | Asynchronous acknowledge, active low |

## Verification
The bench sweeps every combination of bus width, direction, size and address parity, with wait-state counts from zero to two. At each one it checks the strobe pair, the lane placement and the read extraction. A design that swaps the even and odd byte lanes, or that asserts the upper strobe as a lane strobe on an 8-bit bus, returns or drives the wrong byte. A design that skips the synchronizer delay releases the strobes too early. A design that samples read data late picks up the corrupted bus value the bench drives after termination. The bench also keeps the acknowledge low across a request, which catches a design that starts a new cycle on a stale acknowledge.

// File: rtl/abm_pkg.sv
`timescale 1ns/1ps
package abm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ASTB,
    ST_DSTB,
    ST_TERM
  } abm_state_e;

  typedef struct packed {
    logic write;
    logic word;
    logic bus8;
    logic a0;
  } abm_ctl_t;
endpackage

// File: rtl/abm_ack_sync.sv
`timescale 1ns/1ps
module abm_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_n_in,
  output logic ack_o
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= ~ack_n_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[gi] <= 1'b0;
          else     chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign ack_o = chain[STAGES-1];
endmodule

// File: rtl/abm_lane_map.sv
`timescale 1ns/1ps
module abm_lane_map
  import abm_pkg::*;
#(
  parameter int DW = 16
) (
  input  abm_ctl_t        ctl,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   din,
  output logic            up_en,
  output logic            lo_en,
  output logic [DW-1:0]   dout,
  output logic [DW-1:0]   rdata
);
  localparam int HB = DW / 2;

  always_comb begin
    if (ctl.bus8) begin
      up_en = 1'b0;
      lo_en = 1'b1;
      dout  = {{HB{1'b0}}, wdata[HB-1:0]};
      rdata = {{HB{1'b0}}, din[HB-1:0]};
    end else if (ctl.word) begin
      up_en = 1'b1;
      lo_en = 1'b1;
      dout  = wdata;
      rdata = din;
    end else if (!ctl.a0) begin
      up_en = 1'b1;
      lo_en = 1'b0;
      dout  = {wdata[HB-1:0], {HB{1'b0}}};
      rdata = {{HB{1'b0}}, din[DW-1:HB]};
    end else begin
      up_en = 1'b0;
      lo_en = 1'b1;
      dout  = {{HB{1'b0}}, wdata[HB-1:0]};
      rdata = {{HB{1'b0}}, din[HB-1:0]};
    end
  end
endmodule

// File: rtl/abm_fsm.sv
`timescale 1ns/1ps
module abm_fsm
  import abm_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic            req_word,
  input  logic [DW-1:0]   req_wdata,
  input  logic            cfg_bus8,
  input  logic            ack_s,
  input  logic            up_en,
  input  logic            lo_en,
  input  logic [DW-1:0]   map_dout,
  input  logic [DW-1:0]   map_rdata,
  output abm_ctl_t        ctl,
  output logic [DW-1:0]   wdata_q,
  output logic            rsp_done,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-2:0]   bus_addr,
  output logic            bus_as_n,
  output logic            bus_rw,
  output logic            bus_uds_n,
  output logic            bus_lds_n,
  output logic [DW-1:0]   bus_dout,
  output logic            bus_dout_en
);
  abm_state_e state;

  assign req_ready = (state == ST_IDLE) && !ack_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ctl         <= '0;
      wdata_q     <= '0;
      bus_addr    <= '0;
      bus_as_n    <= 1'b1;
      bus_rw      <= 1'b1;
      bus_uds_n   <= 1'b1;
      bus_lds_n   <= 1'b1;
      bus_dout    <= '0;
      bus_dout_en <= 1'b0;
      rsp_rdata   <= '0;
      rsp_done    <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            ctl      <= '{write: req_write, word: req_word,
                          bus8: cfg_bus8, a0: req_addr[0]};
            wdata_q  <= req_wdata;
            bus_addr <= req_addr[AW-1:1];
            bus_rw   <= ~req_write;
            if (cfg_bus8) bus_uds_n <= req_addr[0];
            state    <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          bus_as_n    <= 1'b0;
          bus_dout    <= map_dout;
          bus_dout_en <= ctl.write;
          state       <= ST_ASTB;
        end
        ST_ASTB: begin
          if (ctl.bus8) begin
            bus_lds_n <= 1'b0;
          end else begin
            bus_uds_n <= ~up_en;
            bus_lds_n <= ~lo_en;
          end
          state <= ST_DSTB;
        end
        ST_DSTB: begin
          if (ack_s) begin
            bus_as_n  <= 1'b1;
            bus_lds_n <= 1'b1;
            if (!ctl.bus8) bus_uds_n <= 1'b1;
            if (!ctl.write) rsp_rdata <= map_rdata;
            state <= ST_TERM;
          end
        end
        ST_TERM: begin
          rsp_done    <= 1'b1;
          bus_dout_en <= 1'b0;
          bus_rw      <= 1'b1;
          bus_uds_n   <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  ds_needs_as_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_lds_n || (!ctl.bus8 && !bus_uds_n)) |-> !bus_as_n);

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DSTB && !ack_s) |=> (state == ST_DSTB && !bus_as_n));

  // R4
  rw_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_as_n) |=> (bus_as_n || $stable(bus_rw)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R10
  no_stale_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && ack_s) |=> (state == ST_IDLE));

  // R11
  wdata_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rw && (!bus_lds_n || (!ctl.bus8 && !bus_uds_n))) |-> bus_dout_en);
endmodule

// File: rtl/abm_cycle_engine.sv
`timescale 1ns/1ps
module abm_cycle_engine
  import abm_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic            req_word,
  input  logic [DW-1:0]   req_wdata,
  input  logic            cfg_bus8,
  output logic            rsp_done,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-2:0]   bus_addr,
  output logic            bus_as_n,
  output logic            bus_rw,
  output logic            bus_uds_n,
  output logic            bus_lds_n,
  output logic [DW-1:0]   bus_dout,
  output logic            bus_dout_en,
  input  logic [DW-1:0]   bus_din,
  input  logic            bus_ack_n
);
  logic            ack_s;
  abm_ctl_t        ctl;
  logic [DW-1:0]   wdata_q;
  logic            up_en;
  logic            lo_en;
  logic [DW-1:0]   map_dout;
  logic [DW-1:0]   map_rdata;

  abm_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .ack_n_in (bus_ack_n),
    .ack_o    (ack_s)
  );

  abm_lane_map #(.DW(DW)) u_map (
    .ctl   (ctl),
    .wdata (wdata_q),
    .din   (bus_din),
    .up_en (up_en),
    .lo_en (lo_en),
    .dout  (map_dout),
    .rdata (map_rdata)
  );

  abm_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_word    (req_word),
    .req_wdata   (req_wdata),
    .cfg_bus8    (cfg_bus8),
    .ack_s       (ack_s),
    .up_en       (up_en),
    .lo_en       (lo_en),
    .map_dout    (map_dout),
    .map_rdata   (map_rdata),
    .ctl         (ctl),
    .wdata_q     (wdata_q),
    .rsp_done    (rsp_done),
    .rsp_rdata   (rsp_rdata),
    .bus_addr    (bus_addr),
    .bus_as_n    (bus_as_n),
    .bus_rw      (bus_rw),
    .bus_uds_n   (bus_uds_n),
    .bus_lds_n   (bus_lds_n),
    .bus_dout    (bus_dout),
    .bus_dout_en (bus_dout_en)
  );

  // R5
  lane_select_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.bus8 && !ctl.word && !bus_as_n) |-> (bus_uds_n || bus_lds_n));

  // R7
  a0_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.bus8 && !bus_lds_n) |-> (bus_uds_n == ctl.a0));
endmodule

// File: tb/abm_cycle_engine_tb_top.sv
`timescale 1ns/1ps
module abm_cycle_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        cfg_bus8 = 1'b0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [22:0] bus_addr;
  logic        bus_as_n, bus_rw, bus_uds_n, bus_lds_n, bus_dout_en;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;
  logic        bus_ack_n = 1'b1;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  abm_cycle_engine dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_word(req_word),
    .req_wdata(req_wdata), .cfg_bus8(cfg_bus8), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_as_n(bus_as_n),
    .bus_rw(bus_rw), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .bus_ack_n(bus_ack_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_cycle(input bit b8, input bit wr, input bit wd, input bit a0,
                           input int waits, input logic [23:0] base,
                           input logic [15:0] wdat, input logic [15:0] dval);
    logic [23:0] ad;
    logic        eu, el;
    logic [15:0] edout, erd;
    ad = {base[23:1], a0};
    if (b8) begin
      eu = a0; el = 1'b0;
      edout = {8'h00, wdat[7:0]}; erd = {8'h00, dval[7:0]};
    end else begin
      eu = !(wd || !a0); el = !(wd || a0);
      if (wd) begin edout = wdat; erd = dval; end
      else if (!a0) begin edout = {wdat[7:0], 8'h00}; erd = {8'h00, dval[15:8]}; end
      else begin edout = {8'h00, wdat[7:0]}; erd = {8'h00, dval[7:0]}; end
    end
    @(negedge clk);
    cfg_bus8 = b8; req_write = wr; req_word = wd; req_addr = ad; req_wdata = wdat;
    req_valid = 1'b1;
    chk("R10 ready idle", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 as high at E0", {31'd0, bus_as_n}, 32'd1);
    chk("R2 address", {9'd0, bus_addr}, {9'd0, ad[23:1]});
    chk("R4 direction", {31'd0, bus_rw}, {31'd0, !wr});
    if (b8) chk("R7 a0 pin early", {31'd0, bus_uds_n}, {31'd0, a0});
    @(negedge clk);
    chk("R2 as low at E0+1", {31'd0, bus_as_n}, 32'd0);
    chk("R2 lds not yet", {31'd0, bus_lds_n}, 32'd1);
    chk("R11 dout_en early", {31'd0, bus_dout_en}, {31'd0, wr});
    if (wr) chk(b8 ? "R7 write lane" : "R6 write lane", {16'd0, bus_dout}, {16'd0, edout});
    @(negedge clk);
    chk(b8 ? "R7 strobes" : "R5 strobes", {30'd0, bus_uds_n, bus_lds_n}, {30'd0, eu, el});
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R3 wait hold", {29'd0, bus_as_n, bus_uds_n, bus_lds_n}, {29'd0, 1'b0, eu, el});
    end
    bus_ack_n = 1'b0; bus_din = dval;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R3 sync delay", {29'd0, bus_as_n, bus_uds_n, bus_lds_n}, {29'd0, 1'b0, eu, el});
    end
    @(negedge clk);
    chk("R3 release", {30'd0, bus_as_n, bus_lds_n}, 32'd3);
    chk("R9 done not early", {31'd0, rsp_done}, 32'd0);
    chk("R11 dout_en held", {31'd0, bus_dout_en}, {31'd0, wr});
    bus_din = ~dval;
    @(negedge clk);
    chk("R9 done pulse", {31'd0, rsp_done}, 32'd1);
    chk("R11 dout_en off", {31'd0, bus_dout_en}, 32'd0);
    if (!wr) chk(b8 ? "R7 R8 read data" : "R6 R8 read data", {16'd0, rsp_rdata}, {16'd0, erd});
    chk("R10 ready while ack", {31'd0, req_ready}, 32'd0);
    bus_ack_n = 1'b1;
    @(negedge clk);
    chk("R9 done single", {31'd0, rsp_done}, 32'd0);
    chk("R10 ready sync tail", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R10 ready back", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pins", {27'd0, bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_dout_en},
        {27'd0, 5'b11110});
    chk("R1 reset done/ready", {30'd0, rsp_done, req_ready}, 32'd1);
    for (int idx = 0; idx < 16; idx++) begin
      run_cycle(idx[3], idx[2], idx[1], idx[0], idx % 3, 24'h3A5C00 + 24'(idx * 2),
                16'hA100 ^ 16'(idx * 16'h1357), 16'h5A3C ^ 16'(idx * 16'h0F21));
    end
    // R10: acknowledge held low from a previous responder must block a start
    bus_ack_n = 1'b0;
    repeat (3) @(negedge clk);
    req_addr = 24'h000010; req_write = 1'b0; req_word = 1'b1; cfg_bus8 = 1'b0;
    req_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 stale ack blocks", {30'd0, bus_as_n, req_ready}, 32'd2);
    end
    req_valid = 1'b0;
    bus_ack_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 recovers", {31'd0, req_ready}, 32'd1);
    run_cycle(1'b0, 1'b0, 1'b1, 1'b0, 5, 24'h7FFFFE, 16'h0000, 16'hBEEF);
    run_cycle(1'b1, 1'b1, 1'b1, 1'b1, 4, 24'h000000, 16'hC3A5, 16'h0000);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule